// File: doc/BRIEF.md
# Gate-Synchronized Programmable Clock Divider

This block divides a free-running reference clock by a programmable integer and restarts the phase of the divided clock on every rising edge of an asynchronous gate input. While the gate is high, the output runs at the reference frequency divided by (D+1), where D is the divisor sampled when the gate rose. When the gate drops, the output goes low and stays low until the gate rises again. The output edges always land on reference clock edges, so within one burst the output period is exactly a whole number of reference periods.

The gate is brought into the reference domain by two flops, and its rising edge is found from the synchronized value. This gives a fixed latency from gate to first output edge. A divisor of zero passes the reference clock itself through a latch-based clock gate, so no shortened pulse appears when the gate opens or closes.

Top module: `gate_sync_divider`

## Requirements
- R1: While the gate is low, and after reset, the output is held at 0 with the reference running, whatever the divisor.
- R2: When the gate rises, the output stays 0 through the first two rising reference edges after the gate change and goes to 1 at the third.
- R3: For a divisor D from 1 to 255, the output repeats with a period of D+1 reference cycles. It is 1 for the first ceil((D+1)/2) cycles of each period, counted from the first high cycle, and 0 for the rest.
- R4: For D = 0, the output equals the reference clock (high in its high phase, low in its low phase) from the third rising edge after the gate rose, and it is 0 in both phases before that edge.
- R5: The divisor is captured at the detected gate edge. A change on the divisor inputs while the gate stays high has no effect on the output pattern of that burst.
- R6: After the gate falls, the pattern continues for two more reference cycles. From the third rising edge after the fall, the output is 0 in both phases.
- R7: Every new gate rising edge restarts the pattern at the start of a high portion, however far the previous burst had got through its period.
- R8: D = 255 divides by 256, with 128 high cycles followed by 128 low cycles.
- R9: Asserting the active-low reset forces the output to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 1 | Asynchronous gate; high enables the output |
| div_in | input | DIV_W (8) | Divisor D; the output frequency is the reference divided by D+1 |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
The bench goes after these corner cases:
- Exact gate latency. A design with one synchronizer stage too many or too few starts its first pulse an edge late or early.
- The D = 0 bypass, sampled in both clock phases. Gating it with a flop instead of a latch, or using the wrong enable timing, would add or drop a whole reference pulse at the gate edges.
- The rounding of the high time for odd and even period lengths, including divide-by-256 at the counter's end of range.
- A divisor change in the middle of a burst, which a design that forgot the holding register would follow at once.
- Bursts that end partway through a period followed by a new gate edge, to expose a counter that is not reloaded on restart.
- The two-cycle tail after the gate falls.

// File: rtl/gate_sync_divider.sv
module gate_sync_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             gate_in,
  input  logic [DIV_W-1:0] div_in,
  output logic             clk_out
);

  logic             g1, g2, g3;
  logic             rise;
  logic [DIV_W-1:0] div_q, cnt, cnt_nxt, phase;
  logic [DIV_W:0]   hi_len;
  logic             out_q;
  logic             en_d, en_lat;
  logic             bypass;

  assign rise    = g2 & ~g3;
  assign cnt_nxt = (cnt == '0) ? div_q : cnt - DIV_W'(1);
  assign phase   = div_q - cnt_nxt;
  assign hi_len  = ({1'b0, div_q} + (DIV_W+1)'(2)) >> 1;
  assign bypass  = (div_q == '0);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      g1 <= 1'b0;
      g2 <= 1'b0;
      g3 <= 1'b0;
    end else begin
      g1 <= gate_in;
      g2 <= g1;
      g3 <= g2;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (!g2) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else if (rise) begin
      div_q <= div_in;
      cnt   <= div_in;
      out_q <= 1'b1;
    end else begin
      cnt   <= cnt_nxt;
      out_q <= ({1'b0, phase} < hi_len);
    end
  end

  // enable for the state that holds after the coming edge, caught while the clock is low
  assign en_d = g2 & (rise ? (div_in == '0) : bypass);

  always_latch begin
    if (!rst_n)
      en_lat <= 1'b0;
    else if (!clk_ref)
      en_lat <= en_d;
  end

  assign clk_out = bypass ? (clk_ref & en_lat) : out_q;

  p_first_high_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    rise |=> out_q);

  p_cnt_bound_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cnt <= div_q);

  p_wrap_high_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (g2 && g3 && cnt == '0) |=> out_q);

  p_div_hold_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (g2 && g3) |=> $stable(div_q));

  p_gate_off_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !g2 |=> (!out_q && cnt == '0));

  always @(negedge clk_ref) begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (!out_q && !en_lat);
    end
  end

endmodule

// File: tb/gate_sync_divider_bench.sv
module gate_sync_divider_bench;

  localparam int CLK_P = 10;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       gate_in = 1'b0;
  logic [7:0] div_in  = 8'd0;
  logic       clk_out;

  int checks = 0;
  int errors = 0;

  gate_sync_divider #(.DIV_W(8)) u_gate_sync_divider (
    .clk_ref(clk_ref), .rst_n(rst_n), .gate_in(gate_in),
    .div_in(div_in), .clk_out(clk_out)
  );

  always #(CLK_P/2) clk_ref = ~clk_ref;

  // {divisor[23:16], burst length in cycles[15:0]}
  localparam logic [23:0] VEC [8] = '{
    {8'd0,   16'd6},  {8'd1,   16'd7},  {8'd2,   16'd8},  {8'd3,  16'd9},
    {8'd4,   16'd11}, {8'd7,   16'd21}, {8'd254, 16'd300}, {8'd255, 16'd520}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic logic exp_hi(input int d, input int k);
    if (d == 0) return 1'b1;
    return ((k % (d + 1)) < ((d + 2) / 2));
  endfunction

  task automatic burst(input int d, input int n);
    string tag;
    @(negedge clk_ref);
    div_in  = 8'(d);
    gate_in = 1'b1;
    @(posedge clk_ref); #(CLK_P/4) chk(clk_out, 1'b0, "R2");
    @(posedge clk_ref); #(CLK_P/4) chk(clk_out, 1'b0, "R2");
    for (int k = 0; k < n; k++) begin
      @(posedge clk_ref);
      if (k == 0) tag = "R7";
      else if (k == 2) tag = "R5";
      else if (d == 0) tag = "R4";
      else if (d == 255) tag = "R8";
      else tag = "R3";
      #(CLK_P/4) chk(clk_out, exp_hi(d, k), tag);
      #(CLK_P/2) chk(clk_out, (d == 0) ? 1'b0 : exp_hi(d, k), tag);
      if (k == 1) div_in = ~8'(d);
    end
    gate_in = 1'b0;
    for (int k = n; k < n + 2; k++) begin
      @(posedge clk_ref);
      #(CLK_P/4) chk(clk_out, exp_hi(d, k), "R6");
      #(CLK_P/2) chk(clk_out, (d == 0) ? 1'b0 : exp_hi(d, k), "R6");
    end
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref);
      #(CLK_P/4) chk(clk_out, 1'b0, "R6");
      #(CLK_P/2) chk(clk_out, 1'b0, "R6");
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_ref); #(CLK_P/4) chk(clk_out, 1'b0, "R1");
    end
    #(CLK_P/2) rst_n = 1'b1;
    div_in = 8'd5;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref);
      #(CLK_P/4) chk(clk_out, 1'b0, "R1");
      #(CLK_P/2) chk(clk_out, 1'b0, "R1");
    end
    div_in = 8'd0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_ref);
      #(CLK_P/4) chk(clk_out, 1'b0, "R1");
    end

    for (int i = 0; i < 8; i++)
      burst(int'(VEC[i][23:16]), int'(VEC[i][15:0]));

    // back-to-back bursts ending mid-period: phase restarts each time
    burst(5, 8);
    burst(5, 3);

    // asynchronous reset in the middle of a burst
    @(negedge clk_ref);
    div_in  = 8'd3;
    gate_in = 1'b1;
    repeat (4) @(posedge clk_ref);
    #(CLK_P/4) chk(clk_out, 1'b1, "R3");
    #(CLK_P/8) rst_n = 1'b0;
    #1 chk(clk_out, 1'b0, "R9");
    @(posedge clk_ref); #(CLK_P/4) chk(clk_out, 1'b0, "R9");
    gate_in = 1'b0;
    #(CLK_P/2) rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_ref); #(CLK_P/4) chk(clk_out, 1'b0, "R1");
    end

    // bypass mode after reset, then back to idle
    burst(0, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule